// File: doc/BRIEF.md
# Lockable Control Register File

This block holds a 32-bit control word behind a tiny word-wide register bus, together with a lock word and a key register. Software sets bits in the lock word to freeze groups of control fields. Lock bits can be set but never cleared, so a frozen field keeps its value until the next reset, whatever is later written to the control word.

The key register gates the whole space. Writing the correct 32-bit key opens the space and raises a privileged mode bit and the 3-bit cipher-select field. Writing any other value closes the space and drops those same bits. While the space is closed, reads return zero and only the key register accepts writes.

The current control word drives a dedicated output for the logic it configures. A one-cycle pulse reports that the cipher-select field was written with a mixed value, meaning one that is neither all zeros nor all ones.

Top module: `lcr_top`

## Requirements
- R1: After reset the control word is 0x0C00_6000, the lock word reads 0 and `space_open` is 1.
- R2: The lock word at byte offset 0x04 keeps five bits. A write ORs data bits 4:0 into the stored value, so no lock bit clears before reset. Reads of bits 31:5 return zero.
- R3: Each lock bit freezes fixed control bits. Lock bit 0 freezes bits 6:0, bit 1 freezes bit 7, bit 2 freezes bit 8, bit 3 freezes bits 11:9, and bit 4 freezes bit 12. A control write leaves every frozen bit at its old value.
- R4: A control write at byte offset 0x00 loads write data into every unfrozen writable bit. The writable bits are 30:29, 27:24, 15 and 12:0. Bits 28 and 23:16 always read zero, and bits 14:13 always read one.
- R5: Control bit 31 ignores writes and always reads zero.
- R6: Writing 0x757B_DF0D to the key register at byte offset 0x34 sets control bit 27 and bits 11:9 and sets `space_open`. This holds even when those bits are frozen by a lock.
- R7: Writing any other value to the key register clears control bit 27 and bits 11:9 and clears `space_open`.
- R8: While `space_open` is 0, `reg_rdata` is zero and writes to the control and lock words have no effect. Writes to the key register still act.
- R9: One cycle after an accepted control write whose data bits 11:9 are neither 000 nor 111, `sel_incons` is 1 for exactly one cycle. It stays 0 otherwise.
- R10: The key register and every unmapped offset read zero, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_addr | input | 6 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| space_open | output | 1 | Register space is accessible |
| ctrl_word | output | 32 | Current control word |
| sel_incons | output | 1 | One-cycle mixed cipher-select pulse |

## Verification
The bench resets the block once for every one of the 32 lock combinations. In each run it writes two complementary control patterns around the lock write and compares the result bit by bit. A design with a wrong lock-to-field map, or one that freezes the whole word, fails on specific combinations. The bench also attempts to clear lock bits, which catches a lock word stored by plain assignment. It then closes the space with a bad key, writes to the control and lock words, reopens the space and reads both words back. An implementation that leaks writes or reads while closed shows different values. A key write made with cipher-select frozen must still raise that field. All eight cipher-select codes are swept so that a pulse that is missing, sticky or triggered by 111 is visible.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
    localparam int DW     = 32;
    localparam int LOCK_N = 5;

    // bits loaded by a control write when not frozen
    localparam logic [DW-1:0] CTRL_WR_MASK  = 32'h6F00_9FFF;
    // bits tied high
    localparam logic [DW-1:0] CTRL_ONES     = 32'h0000_6000;
    localparam logic [DW-1:0] CTRL_RST      = 32'h0C00_6000;
    // bits raised or dropped by a key write
    localparam logic [DW-1:0] KEY_CTRL_BITS = 32'h0800_0E00;

    typedef struct packed {
        logic [DW-1:0]     ctrl;
        logic [LOCK_N-1:0] lock;
        logic              open;
        logic              incons;
    } lcr_state_t;

    function automatic logic [DW-1:0] lock_field(input int idx);
        case (idx)
            0:       lock_field = 32'h0000_007F;
            1:       lock_field = 32'h0000_0080;
            2:       lock_field = 32'h0000_0100;
            3:       lock_field = 32'h0000_0E00;
            4:       lock_field = 32'h0000_1000;
            default: lock_field = '0;
        endcase
    endfunction
endpackage

// File: rtl/lcr_lock_mask.sv
module lcr_lock_mask
    import lcr_pkg::*;
#(
    parameter int N = LOCK_N
) (
    input  logic [N-1:0]  lock,
    output logic [DW-1:0] frozen
);
    logic [DW-1:0] part [N];

    for (genvar i = 0; i < N; i++) begin : g_field
        assign part[i] = lock[i] ? lock_field(i) : '0;
    end

    always_comb begin
        frozen = '0;
        for (int i = 0; i < N; i++) begin
            frozen = frozen | part[i];
        end
    end
endmodule

// File: rtl/lcr_key_check.sv
module lcr_key_check #(
    parameter int          W   = 32,
    parameter logic [W-1:0] KEY = 32'h757B_DF0D
) (
    input  logic [W-1:0] data,
    output logic         hit
);
    assign hit = (data == KEY);
endmodule

// File: rtl/lcr_read_mux.sv
module lcr_read_mux
    import lcr_pkg::*;
#(
    parameter int              AW       = 6,
    parameter logic [AW-1:0]   CTRL_OFF = 6'h00,
    parameter logic [AW-1:0]   LOCK_OFF = 6'h04
) (
    input  logic [AW-1:0]     addr,
    input  logic              open,
    input  logic [DW-1:0]     ctrl,
    input  logic [LOCK_N-1:0] lock,
    output logic [DW-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        if (open) begin
            if (addr == CTRL_OFF)      rdata = ctrl;
            else if (addr == LOCK_OFF) rdata = {{(DW-LOCK_N){1'b0}}, lock};
        end
    end
endmodule

// File: rtl/lcr_top.sv
module lcr_top
    import lcr_pkg::*;
#(
    parameter int            AW       = 6,
    parameter logic [AW-1:0] CTRL_OFF = 6'h00,
    parameter logic [AW-1:0] LOCK_OFF = 6'h04,
    parameter logic [AW-1:0] KEY_OFF  = 6'h34,
    parameter logic [31:0]   KEY      = 32'h757B_DF0D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          space_open,
    output logic [31:0]   ctrl_word,
    output logic          sel_incons
);
    lcr_state_t    s_d, s_q;
    logic [DW-1:0] frozen;
    logic          key_hit;
    logic          wr_ctrl_d, wr_lock_d, wr_key_d;

    lcr_lock_mask #(.N(LOCK_N)) u_mask (.lock(s_q.lock), .frozen(frozen));
    lcr_key_check #(.W(DW), .KEY(KEY)) u_key (.data(reg_wdata), .hit(key_hit));
    lcr_read_mux #(.AW(AW), .CTRL_OFF(CTRL_OFF), .LOCK_OFF(LOCK_OFF)) u_rd (
        .addr(reg_addr), .open(s_q.open), .ctrl(s_q.ctrl), .lock(s_q.lock),
        .rdata(reg_rdata)
    );

    always_comb begin
        wr_ctrl_d = reg_we && s_q.open && (reg_addr == CTRL_OFF);
        wr_lock_d = reg_we && s_q.open && (reg_addr == LOCK_OFF);
        wr_key_d  = reg_we && (reg_addr == KEY_OFF);

        s_d        = s_q;
        s_d.incons = 1'b0;
        if (wr_ctrl_d) begin
            s_d.ctrl   = (s_q.ctrl & (~CTRL_WR_MASK | frozen))
                       | (reg_wdata & CTRL_WR_MASK & ~frozen);
            s_d.incons = (reg_wdata[11:9] != 3'b000) && (reg_wdata[11:9] != 3'b111);
        end
        if (wr_lock_d) begin
            s_d.lock = s_q.lock | reg_wdata[LOCK_N-1:0];
        end
        if (wr_key_d) begin
            if (key_hit) begin
                s_d.ctrl = s_q.ctrl | KEY_CTRL_BITS;
                s_d.open = 1'b1;
            end else begin
                s_d.ctrl = s_q.ctrl & ~KEY_CTRL_BITS;
                s_d.open = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl   <= CTRL_RST;
            s_q.lock   <= '0;
            s_q.open   <= 1'b1;
            s_q.incons <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_word  = s_q.ctrl;
    assign space_open = s_q.open;
    assign sel_incons = s_q.incons;

    // R2: lock bits never fall
    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.lock & $past(s_q.lock)) == $past(s_q.lock)));

    // R3: frozen bits survive a control write
    p_frozen_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == CTRL_OFF && frozen != '0)
        |=> ((ctrl_word & $past(frozen)) == ($past(ctrl_word) & $past(frozen))));

    // R5: bit 31 never set
    p_top_bit_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_word[31]);

    // R6: correct key opens and raises privileged bits
    p_key_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == KEY_OFF && reg_wdata == KEY)
        |=> (space_open && ctrl_word[27] && ctrl_word[11:9] == 3'b111));

    // R8: closed space ignores control writes
    p_closed_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!space_open && reg_we && reg_addr == CTRL_OFF) |=> $stable(ctrl_word));

    // R9: pulse only after a write in the previous cycle
    p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_incons) |-> $past(reg_we && reg_addr == CTRL_OFF));
endmodule

// File: tb/sim_lcr_top.sv
`timescale 1ns/1ps
module sim_lcr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, ctrl_word;
    logic        space_open, sel_incons;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] WM   = 32'h6F00_9FFF;
    localparam logic [31:0] ONES = 32'h0000_6000;
    localparam logic [31:0] GOOD = 32'h757B_DF0D;

    always #2.5 clk = ~clk;

    lcr_top u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .space_open(space_open),
        .ctrl_word(ctrl_word), .sel_incons(sel_incons));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        reg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] fz(input logic [4:0] l);
        logic [31:0] m = '0;
        if (l[0]) m |= 32'h7F;
        if (l[1]) m |= 32'h80;
        if (l[2]) m |= 32'h100;
        if (l[3]) m |= 32'hE00;
        if (l[4]) m |= 32'h1000;
        return m;
    endfunction

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, ea, e;
        do_reset();
        // R1 reset state
        check("R1 ctrl", ctrl_word, 32'h0C00_6000);
        check("R1 open", {31'b0, space_open}, 32'd1);
        rd(6'h04, v); check("R1 lock", v, 32'd0);
        check("R9 idle", {31'b0, sel_incons}, 32'd0);

        // R4/R5 write all ones
        wr(6'h00, 32'hFFFF_FFFF);
        check("R4 all ones", ctrl_word, WM | ONES);
        check("R5 bit31", {31'b0, ctrl_word[31]}, 32'd0);
        wr(6'h00, 32'h0000_0000);
        rd(6'h00, v); check("R4 zeros keep 14:13", v, ONES);
        // R10 unmapped and key reads
        rd(6'h34, v); check("R10 key read", v, 32'd0);
        wr(6'h08, 32'hFFFF_FFFF);
        rd(6'h08, v); check("R10 unmapped read", v, 32'd0);
        check("R10 unmapped write", ctrl_word, ONES);

        // R2/R3 sweep over all lock sets and two pattern pairs
        for (int l = 0; l < 32; l++) begin
            for (int p = 0; p < 2; p++) begin
                logic [31:0] a;
                a = (p == 0) ? 32'h5A5A_5A5A : 32'hFFFF_FFFF;
                do_reset();
                wr(6'h00, a);
                ea = (a & WM) | ONES;
                wr(6'h04, 32'hFFFF_FFE0 | l);
                rd(6'h04, v); check("R2 lock read", v, l);
                wr(6'h00, ~a);
                e = (ea & fz(l[4:0])) | (~a & WM & ~fz(l[4:0])) | ONES;
                check("R3 locked merge", ctrl_word, e);
            end
            wr(6'h04, 32'h0);
            rd(6'h04, v); check("R2 sticky", v, l);
        end

        // R6 key overrides locked cipher field
        do_reset();
        wr(6'h00, 32'h0);
        wr(6'h04, 32'h8);
        wr(6'h34, GOOD);
        check("R6 key bits", ctrl_word, 32'h0800_6E00);
        check("R6 open", {31'b0, space_open}, 32'd1);

        // R7 bad key, R8 closed space
        wr(6'h34, GOOD ^ 32'h1);
        check("R7 bits dropped", ctrl_word, ONES);
        check("R7 closed", {31'b0, space_open}, 32'd0);
        rd(6'h00, v); check("R8 read zero", v, 32'd0);
        wr(6'h00, 32'h0000_0055);
        wr(6'h04, 32'h1);
        check("R8 ctrl ignored", ctrl_word, ONES);
        check("R9 no pulse closed", {31'b0, sel_incons}, 32'd0);
        wr(6'h34, GOOD);
        rd(6'h04, v); check("R8 lock ignored", v, 32'h8);
        rd(6'h00, v); check("R8 reopen", v, 32'h0800_6E00);

        // R9 sweep of cipher-select codes
        do_reset();
        for (int c = 0; c < 8; c++) begin
            wr(6'h00, c << 9);
            check("R9 pulse", {31'b0, sel_incons}, (c != 0 && c != 7) ? 32'd1 : 32'd0);
            @(negedge clk);
            check("R9 one cycle", {31'b0, sel_incons}, 32'd0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule